// File: doc/BRIEF.md
# Serial address receive filter

This block sits in a serial link receiver, between the character decoder and the receive FIFO. Every decoded character arrives as a 12-bit word whose upper three bits give its format. A character with format `111` carries a serial address instead of payload. The filter compares that address with a locally held compare value. It keeps a sticky acceptance flag that the most recent address character sets or clears. Data characters pass to the FIFO write side only while the flag is set.

The compare value is written and read through a small register port. When the compare value is all ones, it matches every address. A resync pulse, issued for example when a link self-test finishes, reloads the acceptance flag from the compare value. With the match-all value in place, reception can therefore resume without first seeing an address. A configuration input chooses whether a matching address character is itself forwarded or dropped. Address matching as a whole can be switched off.

Top module: `saf_top`

## Requirements
- R1: After reset, `out_valid` is 0, `reg_rdata` equals the parameter `CMP_RESET` (default 0), and `accept_o` is 1 only if `CMP_RESET` is all ones.
- R2: A character is an address character exactly when `char_in[11:9]` is `111`. Its address is `char_in[ADDR_W-1:0]`. Characters of the other seven formats never change `accept_o`.
- R3: An address character that matches sets `accept_o`, and one that does not match clears it, both visible on the clock edge that samples the character. A match means the address equals the compare value.
- R4: With `match_en` high, a data character is forwarded only if `accept_o` was 1 before the edge that samples it.
- R5: A compare value of all ones matches every address.
- R6: A matching address character is forwarded when `keep_addr` is 1 and dropped when it is 0. A non-matching address character is never forwarded while `match_en` is high.
- R7: A register write updates `reg_rdata` at the next edge and leaves `accept_o` unchanged. An address character sampled on the same edge as the write is compared with the old value.
- R8: When `resync` is high, `accept_o` becomes 1 if the compare value is all ones and 0 otherwise, and the character sampled that cycle is dropped.
- R9: With `match_en` low, every data character is forwarded, and an address character is forwarded if and only if `keep_addr` is 1.
- R10: A forwarded character appears on `out_char` with `out_valid` high exactly one clock after it is sampled, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | A decoded character is present this cycle |
| char_in | input | CHAR_W | Decoded character, format in bits 11:9 |
| match_en | input | 1 | Enable address filtering |
| keep_addr | input | 1 | Forward matching address characters |
| resync | input | 1 | Reload acceptance from the compare value |
| reg_wr | input | 1 | Write strobe for the compare value |
| reg_wdata | input | ADDR_W | Compare value to write |
| reg_rdata | output | ADDR_W | Current compare value |
| out_valid | output | 1 | FIFO write strobe |
| out_char | output | CHAR_W | Character to write into the FIFO |
| accept_o | output | 1 | Current acceptance state |

## Verification
The hardest case to reach is a collision: a compare write landing on the same edge as an address character. In that case the old value must decide the match, while the new value decides only from the next address. The stimulus writes one value, then issues a second write together with an address equal to the new value but not the old one, and checks that acceptance clears. A second address then shows the new value in force. The main sweep covers every compare value against every address, with both settings of address forwarding, at a narrow address width.

// File: rtl/saf_pkg.sv
package saf_pkg;
  localparam int FMT_W = 3;
  localparam logic [FMT_W-1:0] FMT_ADDR = 3'b111;

  function automatic logic is_addr_fmt(input logic [FMT_W-1:0] fmt);
    return fmt == FMT_ADDR;
  endfunction
endpackage

// File: rtl/saf_cmp_reg.sv
module saf_cmp_reg #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] cmp_q,
  output logic              match_all
);
  logic [ADDR_W-1:0] cmp_d;

  always_comb begin
    cmp_d = cmp_q;
    if (wr_en) cmp_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= RST_VAL;
    else        cmp_q <= cmp_d;
  end

  assign match_all = &cmp_q;

  p_wr_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cmp_q == $past(wdata));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cmp_q));
endmodule

// File: rtl/saf_matcher.sv
module saf_matcher #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] cmp_val,
  input  logic              match_all,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [ADDR_W-1:0] bit_eq;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_eq
    assign bit_eq[i] = ~(cmp_val[i] ^ addr[i]);
  end

  assign hit = match_all | (&bit_eq);

  always_comb begin
    if (match_all) p_all_hits_r5: assert (hit);
  end
endmodule

// File: rtl/saf_accept_fsm.sv
module saf_accept_fsm #(
  parameter logic RST_ACC = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_seen,
  input  logic hit,
  input  logic resync,
  input  logic match_all,
  output logic accept_q
);
  logic accept_d;

  always_comb begin
    accept_d = accept_q;
    if (resync)         accept_d = match_all;
    else if (addr_seen) accept_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) accept_q <= RST_ACC;
    else        accept_q <= accept_d;
  end

  p_resync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> accept_q == $past(match_all));
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!resync && !addr_seen) |=> $stable(accept_q));
endmodule

// File: rtl/saf_top.sv
module saf_top #(
  parameter int CHAR_W = 12,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMP_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_valid,
  input  logic [CHAR_W-1:0] char_in,
  input  logic              match_en,
  input  logic              keep_addr,
  input  logic              resync,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_char,
  output logic              accept_o
);
  import saf_pkg::*;

  localparam int FMT_LSB = CHAR_W - FMT_W;
  localparam logic RST_ACC = &CMP_RESET;

  logic              is_addr;
  logic              addr_seen;
  logic [ADDR_W-1:0] cmp_q;
  logic              match_all;
  logic              hit;
  logic              accept_q;
  logic              fwd;
  logic              valid_d;
  logic [CHAR_W-1:0] char_d;
  logic              valid_q;
  logic [CHAR_W-1:0] char_q;

  assign is_addr   = is_addr_fmt(char_in[CHAR_W-1:FMT_LSB]);
  assign addr_seen = char_valid && is_addr;

  saf_cmp_reg #(.ADDR_W(ADDR_W), .RST_VAL(CMP_RESET)) cmp_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wdata(reg_wdata),
    .cmp_q(cmp_q), .match_all(match_all)
  );

  saf_matcher #(.ADDR_W(ADDR_W)) match_i (
    .cmp_val(cmp_q), .match_all(match_all),
    .addr(char_in[ADDR_W-1:0]), .hit(hit)
  );

  saf_accept_fsm #(.RST_ACC(RST_ACC)) fsm_i (
    .clk(clk), .rst_n(rst_n), .addr_seen(addr_seen), .hit(hit),
    .resync(resync), .match_all(match_all), .accept_q(accept_q)
  );

  always_comb begin
    fwd = 1'b0;
    if (char_valid && !resync) begin
      if (is_addr) fwd = keep_addr && (hit || !match_en);
      else         fwd = accept_q || !match_en;
    end
  end

  always_comb begin
    valid_d = fwd;
    char_d  = char_q;
    if (fwd) char_d = char_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      char_q  <= '0;
    end else begin
      valid_q <= valid_d;
      char_q  <= char_d;
    end
  end

  assign out_valid = valid_q;
  assign out_char  = char_q;
  assign reg_rdata = cmp_q;
  assign accept_o  = accept_q;

  p_data_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !is_addr && match_en && !accept_q) |=> !out_valid);
  p_addr_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_seen && !keep_addr) |=> !out_valid);
  p_resync_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !out_valid);
  p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !is_addr && !match_en && !resync) |=> out_valid);
  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(char_valid));
  p_write_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !addr_seen && !resync) |=> $stable(accept_o));
endmodule

// File: tb/saf_top_tb_top.sv
module saf_top_tb_top;
  localparam int CW = 12;
  localparam int AW = 4;
  localparam logic [AW-1:0] ALL1 = '1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          char_valid, match_en, keep_addr, resync, reg_wr;
  logic [CW-1:0] char_in;
  logic [AW-1:0] reg_wdata, reg_rdata;
  logic          out_valid, accept_o;
  logic [CW-1:0] out_char;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  saf_top #(.CHAR_W(CW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_in(char_in),
    .match_en(match_en), .keep_addr(keep_addr), .resync(resync),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .out_valid(out_valid), .out_char(out_char), .accept_o(accept_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [CW-1:0] ch, input logic wr,
                     input logic [AW-1:0] wd, input logic rs);
    char_valid = v; char_in = ch; reg_wr = wr; reg_wdata = wd; resync = rs;
    @(posedge clk);
    @(negedge clk);
    char_valid = 1'b0; reg_wr = 1'b0; resync = 1'b0;
  endtask

  function automatic logic [CW-1:0] addr_ch(input logic [AW-1:0] a);
    return {3'b111, 5'b10100, a};
  endfunction

  function automatic logic [CW-1:0] data_ch(input logic [2:0] f, input logic [AW-1:0] a);
    return {f, 5'b01011, a};
  endfunction

  initial begin
    logic exp_acc;
    rst_n = 1'b0; char_valid = 1'b0; char_in = '0; match_en = 1'b1;
    keep_addr = 1'b0; resync = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 accept", accept_o, 0);
    chk("R1 rdata", reg_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    exp_acc = 1'b0;

    // data blocked before any address (R4)
    cyc(1, data_ch(3'b000, 4'h5), 0, '0, 0);
    chk("R4 blocked before address", out_valid, 0);

    // full sweep: compare value x address x keep_addr (R3 R5 R6 R4 R10 R7)
    for (int k = 0; k < 2; k++) begin
      keep_addr = k[0];
      for (int c = 0; c < 16; c++) begin
        cyc(0, '0, 1, c[AW-1:0], 0);
        chk("R7 rdata after write", reg_rdata, c);
        chk("R7 accept kept on write", accept_o, exp_acc);
        for (int a = 0; a < 16; a++) begin
          logic h;
          h = (a == c) || (c == 15);
          cyc(1, addr_ch(a[AW-1:0]), 0, '0, 0);
          exp_acc = h;
          chk("R3 R5 accept after address", accept_o, h);
          chk("R6 address forwarding", out_valid, k[0] && h);
          if (k[0] && h) chk("R10 address char", out_char, addr_ch(a[AW-1:0]));
          cyc(1, data_ch(3'b010, a[AW-1:0]), 0, '0, 0);
          chk("R4 data gating", out_valid, h);
          if (h) chk("R10 data char", out_char, data_ch(3'b010, a[AW-1:0]));
        end
      end
    end

    // formats other than 111 never touch acceptance (R2)
    keep_addr = 1'b1;
    cyc(0, '0, 1, 4'h3, 0);
    cyc(1, addr_ch(4'h3), 0, '0, 0);
    chk("R2 setup accept", accept_o, 1);
    for (int f = 0; f < 7; f++) begin
      cyc(1, data_ch(f[2:0], 4'h9), 0, '0, 0);
      chk("R2 other format no effect", accept_o, 1);
      chk("R2 other format forwarded as data", out_valid, 1);
    end

    // write colliding with address: old value compared (R7)
    cyc(0, '0, 1, 4'h6, 0);
    cyc(1, addr_ch(4'h6), 0, '0, 0);
    chk("R7 setup", accept_o, 1);
    cyc(1, addr_ch(4'h9), 1, 4'h9, 0);
    chk("R7 same-edge write uses old value", accept_o, 0);
    cyc(1, addr_ch(4'h9), 0, '0, 0);
    chk("R7 new value on next address", accept_o, 1);

    // resync (R8)
    cyc(1, data_ch(3'b001, 4'h1), 0, '0, 1);
    chk("R8 resync non-all-ones clears", accept_o, 0);
    chk("R8 char dropped on resync", out_valid, 0);
    cyc(0, '0, 1, ALL1, 0);
    chk("R8 write keeps accept", accept_o, 0);
    cyc(0, '0, 0, '0, 1);
    chk("R8 resync with match-all sets", accept_o, 1);
    cyc(1, data_ch(3'b100, 4'h2), 0, '0, 0);
    chk("R8 data flows after resync", out_valid, 1);

    // matching disabled (R9)
    cyc(0, '0, 1, 4'h0, 0);
    cyc(1, addr_ch(4'h7), 0, '0, 0);
    chk("R9 setup accept cleared", accept_o, 0);
    match_en = 1'b0;
    for (int k = 0; k < 2; k++) begin
      keep_addr = k[0];
      cyc(1, data_ch(3'b011, 4'hA), 0, '0, 0);
      chk("R9 data forwarded", out_valid, 1);
      cyc(1, addr_ch(4'hB), 0, '0, 0);
      chk("R9 address per keep_addr", out_valid, k[0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule